// File: doc/BRIEF.md
# Serial Flash Erase Sequencer

This block erases a byte range of a page-organised serial flash. It talks to the flash through a byte-level SPI transaction port and never drives bits itself. The port has three parts: a select line that frames each transaction, a send-byte handshake and a receive-byte handshake. A request is a start byte address and a byte length, together with the page size, the page-address shift and the idle gap between status polls. The block captures these values in the cycle it accepts the request.

First the block divides the start address and the length by the page size. It does this with a serial divider, so a page size that is not a power of two costs no wide divider. Each pass then picks one of two erases: an eight-page block erase when the current page is block-aligned and enough pages remain, or a single-page erase otherwise. The block sends a four-byte erase frame and then polls the status register until the device reports ready. It then advances through the range. When the range is used up, it pulses done. A request that is not page-aligned is rejected with an error pulse and produces no traffic on the port.

Top module: `flash_erase_seq`

## Requirements
- R1: A request whose start address or length is not a whole multiple of the page size, or whose page size is zero, ends with a one-cycle `err_o` pulse. No `done_o` pulse is given and `spi_cs_o` never asserts for that request.
- R2: Each erase frame begins with opcode 0x50 (block erase) when the current page number has its three low bits at zero and at least 8 pages remain. Otherwise the frame begins with opcode 0x81 (page erase).
- R3: An erase frame is exactly 4 bytes. After the opcode it carries bits 23:16 and then bits 15:8 of the device address, followed by a 0x00 byte. The device address is the page number shifted left by `page_shift_i`, truncated to 24 bits.
- R4: After every erase frame the block sends status-poll frames. Each poll frame is the byte 0xD7 followed by one received byte. Polling repeats until bit 7 of the received status is 1. The next erase frame starts only after a ready status.
- R5: After a ready status, the page number and the remaining page count change by 8 following a block erase and by 1 following a page erase. Erasing continues until no pages remain.
- R6: `spi_cs_o` is low for at least one cycle between any two frames. Between two status polls it is low for at least `poll_gap_i`+1 cycles.
- R7: `busy_o` rises in the cycle after a start is accepted and stays high through the single cycle in which `done_o` or `err_o` pulses. After that the block returns to idle with all outputs low.
- R8: A start pulse received while `busy_o` is high is ignored. The frame sequence continues to follow the request already accepted.
- R9: A page-aligned request of length zero gives a `done_o` pulse with no SPI traffic.
- R10: `tx_valid_o` and `tx_data_o` are held until `tx_ready_i` is seen. `rx_req_o` is held until `rx_valid_i` is seen. `rx_req_o` is only raised while `spi_cs_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, accepted only when idle |
| start_addr_i | input | ADDR_W | Start byte address of the range |
| len_i | input | ADDR_W | Length of the range in bytes |
| page_size_i | input | PSIZE_W | Page size in bytes |
| page_shift_i | input | SHIFT_W | Left shift from page number to device address |
| poll_gap_i | input | GAP_W | Extra idle cycles between status polls |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle pulse when the range is erased |
| err_o | output | 1 | One-cycle pulse when a request is rejected |
| spi_cs_o | output | 1 | Transaction select, high while a frame is open |
| tx_valid_o | output | 1 | A byte is offered to the port |
| tx_data_o | output | 8 | Byte offered to the port |
| tx_ready_i | input | 1 | Port takes the offered byte |
| rx_req_o | output | 1 | Request for one received byte |
| rx_valid_i | input | 1 | Received byte is present |
| rx_data_i | input | 8 | Received byte |

## Verification
Randomly drawn ranges with page sizes of 256, 264, 512 and 528 bytes and varied shifts exercise the choice between block and page erase. Each device address is compared against a model of the page walk. Directed ranges isolate the cases around the block choice: one starting on a block boundary with exactly two blocks, one that starts one page early and must fall back to a page erase, and one that is aligned but one page short of a block. Misaligned starts, misaligned lengths, a zero page size and a zero length separate rejection from an empty success. Busy status bytes with random low bits, random handshake stalls and a start pulse injected mid-run show that only bit 7 ends polling, that handshakes hold their data, and that a late request cannot disturb the current one.

// File: rtl/ferase_pkg.sv
package ferase_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DIV_ADDR,
        ST_DIV_LEN,
        ST_CMD,
        ST_CMD_GAP,
        ST_POLL_OP,
        ST_POLL_RD,
        ST_POLL_END,
        ST_GAP,
        ST_END
    } seq_state_e;

    localparam logic [7:0] OPC_PAGE_ERASE  = 8'h81;
    localparam logic [7:0] OPC_BLOCK_ERASE = 8'h50;
    localparam logic [7:0] OPC_STATUS      = 8'hD7;
    localparam int         BLOCK_PAGES     = 8;
    localparam int         BLOCK_LOG2      = 3;
    localparam int         READY_BIT       = 7;
    localparam int         CMD_BYTES       = 4;

endpackage

// File: rtl/ferase_div.sv
// Serial restoring divider: one quotient bit per cycle, W cycles per division.
module ferase_div #(
    parameter int W  = 24,
    parameter int DW = 12
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          start_i,
    input  logic [W-1:0]  dividend_i,
    input  logic [DW-1:0] divisor_i,
    output logic          done_o,
    output logic [W-1:0]  quot_o,
    output logic [W-1:0]  rem_o
);
    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        logic [W-1:0]  quot;
        logic [W-1:0]  rem;
        logic [DW-1:0] dvs;
        logic [CW-1:0] cnt;
        logic          done;
    } div_t;

    div_t d, q;
    logic [W:0] trial;
    logic [W:0] dvs_ext;
    logic [W:0] diff;

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        trial   = {q.rem, q.quot[W-1]};
        dvs_ext = '0;
        dvs_ext[DW-1:0] = q.dvs;
        diff    = trial - dvs_ext;
        if (start_i) begin
            d.quot = dividend_i;
            d.rem  = '0;
            d.dvs  = divisor_i;
            d.cnt  = CW'(W);
        end else if (q.cnt != '0) begin
            if (trial >= dvs_ext) begin
                d.rem  = diff[W-1:0];
                d.quot = {q.quot[W-2:0], 1'b1};
            end else begin
                d.rem  = trial[W-1:0];
                d.quot = {q.quot[W-2:0], 1'b0};
            end
            d.cnt  = q.cnt - CW'(1);
            d.done = (q.cnt == CW'(1));
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign done_o = q.done;
    assign quot_o = q.quot;
    assign rem_o  = q.rem;
endmodule

// File: rtl/ferase_step_plan.sv
// Chooses the erase kind for the current page and forms the command bytes.
module ferase_step_plan
    import ferase_pkg::*;
#(
    parameter int AW = 24,
    parameter int SW = 4
) (
    input  logic [AW-1:0] page_i,
    input  logic [AW-1:0] left_i,
    input  logic [SW-1:0] shift_i,
    output logic [7:0]    opcode_o,
    output logic [7:0]    addr_hi_o,
    output logic [7:0]    addr_mid_o,
    output logic [AW-1:0] step_o
);
    logic use_block;
    logic [15:0] addr_top;

    always_comb begin
        use_block  = (page_i[BLOCK_LOG2-1:0] == '0) && (left_i >= AW'(BLOCK_PAGES));
        opcode_o   = use_block ? OPC_BLOCK_ERASE : OPC_PAGE_ERASE;
        step_o     = use_block ? AW'(BLOCK_PAGES) : AW'(1);
        addr_top   = 16'((page_i << shift_i) >> 8);
        addr_hi_o  = addr_top[15:8];
        addr_mid_o = addr_top[7:0];
    end
endmodule

// File: rtl/ferase_gap_timer.sv
// Down-counter that spaces status polls.
module ferase_gap_timer #(
    parameter int GW = 8
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          load_i,
    input  logic [GW-1:0] load_val_i,
    output logic          expired_o
);
    logic [GW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)              cnt_d = load_val_i;
        else if (cnt_q != '0)    cnt_d = cnt_q - GW'(1);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
    import ferase_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int PSIZE_W = 12,
    parameter int SHIFT_W = 4,
    parameter int GAP_W   = 8
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               start_i,
    input  logic [ADDR_W-1:0]  start_addr_i,
    input  logic [ADDR_W-1:0]  len_i,
    input  logic [PSIZE_W-1:0] page_size_i,
    input  logic [SHIFT_W-1:0] page_shift_i,
    input  logic [GAP_W-1:0]   poll_gap_i,
    output logic               busy_o,
    output logic               done_o,
    output logic               err_o,
    output logic               spi_cs_o,
    output logic               tx_valid_o,
    output logic [7:0]         tx_data_o,
    input  logic               tx_ready_i,
    output logic               rx_req_o,
    input  logic               rx_valid_i,
    input  logic [7:0]         rx_data_i
);
    localparam int IDX_W = $clog2(CMD_BYTES);

    typedef struct packed {
        seq_state_e         st;
        logic [ADDR_W-1:0]  page;
        logic [ADDR_W-1:0]  left;
        logic [IDX_W-1:0]   idx;
        logic               bad;
        logic               rdy;
        logic [PSIZE_W-1:0] psz;
        logic [SHIFT_W-1:0] shf;
        logic [GAP_W-1:0]   gap;
    } ctl_t;

    ctl_t d, q;

    logic               div_start, div_done;
    logic [ADDR_W-1:0]  div_dividend, div_quot, div_rem;
    logic [PSIZE_W-1:0] div_divisor;
    logic               tmr_load, tmr_expired;
    logic [7:0]         plan_op, plan_hi, plan_mid, cmd_byte;
    logic [ADDR_W-1:0]  plan_step;
    logic               unused_status_bits;

    assign unused_status_bits = ^rx_data_i[6:0];

    ferase_div #(.W(ADDR_W), .DW(PSIZE_W)) div_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .start_i    (div_start),
        .dividend_i (div_dividend),
        .divisor_i  (div_divisor),
        .done_o     (div_done),
        .quot_o     (div_quot),
        .rem_o      (div_rem)
    );

    ferase_step_plan #(.AW(ADDR_W), .SW(SHIFT_W)) plan_i (
        .page_i     (q.page),
        .left_i     (q.left),
        .shift_i    (q.shf),
        .opcode_o   (plan_op),
        .addr_hi_o  (plan_hi),
        .addr_mid_o (plan_mid),
        .step_o     (plan_step)
    );

    ferase_gap_timer #(.GW(GAP_W)) gap_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (tmr_load),
        .load_val_i (q.gap),
        .expired_o  (tmr_expired)
    );

    always_comb begin
        unique case (q.idx)
            IDX_W'(0): cmd_byte = plan_op;
            IDX_W'(1): cmd_byte = plan_hi;
            IDX_W'(2): cmd_byte = plan_mid;
            default:   cmd_byte = 8'h00;
        endcase
    end

    always_comb begin
        d            = q;
        div_start    = 1'b0;
        div_dividend = q.left;
        div_divisor  = q.psz;
        tmr_load     = 1'b0;
        spi_cs_o     = 1'b0;
        tx_valid_o   = 1'b0;
        tx_data_o    = OPC_STATUS;
        rx_req_o     = 1'b0;
        unique case (q.st)
            ST_IDLE: if (start_i) begin
                d.st         = ST_DIV_ADDR;
                d.left       = len_i;
                d.psz        = page_size_i;
                d.shf        = page_shift_i;
                d.gap        = poll_gap_i;
                d.bad        = 1'b0;
                div_start    = 1'b1;
                div_dividend = start_addr_i;
                div_divisor  = page_size_i;
            end
            ST_DIV_ADDR: if (div_done) begin
                d.page    = div_quot;
                d.bad     = (div_rem != '0);
                div_start = 1'b1;
                d.st      = ST_DIV_LEN;
            end
            ST_DIV_LEN: if (div_done) begin
                d.left = div_quot;
                d.bad  = q.bad || (div_rem != '0) || (q.psz == '0);
                d.idx  = '0;
                d.st   = (d.bad || div_quot == '0) ? ST_END : ST_CMD;
            end
            ST_CMD: begin
                spi_cs_o   = 1'b1;
                tx_valid_o = 1'b1;
                tx_data_o  = cmd_byte;
                if (tx_ready_i) begin
                    d.idx = q.idx + IDX_W'(1);
                    if (q.idx == IDX_W'(CMD_BYTES - 1)) d.st = ST_CMD_GAP;
                end
            end
            ST_CMD_GAP: d.st = ST_POLL_OP;
            ST_POLL_OP: begin
                spi_cs_o   = 1'b1;
                tx_valid_o = 1'b1;
                if (tx_ready_i) d.st = ST_POLL_RD;
            end
            ST_POLL_RD: begin
                spi_cs_o = 1'b1;
                rx_req_o = 1'b1;
                if (rx_valid_i) begin
                    d.rdy = rx_data_i[READY_BIT];
                    d.st  = ST_POLL_END;
                end
            end
            ST_POLL_END: begin
                if (q.rdy) begin
                    d.page = q.page + plan_step;
                    d.left = q.left - plan_step;
                    d.idx  = '0;
                    d.st   = (q.left == plan_step) ? ST_END : ST_CMD;
                end else begin
                    tmr_load = 1'b1;
                    d.st     = ST_GAP;
                end
            end
            ST_GAP: if (tmr_expired) d.st = ST_POLL_OP;
            ST_END: d.st = ST_IDLE;
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign busy_o = (q.st != ST_IDLE);
    assign done_o = (q.st == ST_END) && !q.bad;
    assign err_o  = (q.st == ST_END) && q.bad;
endmodule

// File: rtl/ferase_checker.sv
module ferase_checker #(
    parameter int GAP_W = 8
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             start_i,
    input logic [GAP_W-1:0] poll_gap_i,
    input logic             busy_o,
    input logic             done_o,
    input logic             err_o,
    input logic             spi_cs_o,
    input logic             tx_valid_o,
    input logic [7:0]       tx_data_o,
    input logic             tx_ready_i,
    input logic             rx_req_o,
    input logic             rx_valid_i,
    input logic [7:0]       rx_data_i
);
    logic             seen_cs_q;
    logic             poll_busy_q;
    logic             first_byte_q;
    logic [GAP_W-1:0] gap_q;
    logic [GAP_W:0]   low_cnt_q;
    logic             unused_chk_bits;

    assign unused_chk_bits = ^rx_data_i[6:0];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seen_cs_q    <= 1'b0;
            poll_busy_q  <= 1'b0;
            first_byte_q <= 1'b1;
            gap_q        <= '0;
            low_cnt_q    <= '0;
        end else begin
            if (start_i && !busy_o) begin
                seen_cs_q   <= 1'b0;
                poll_busy_q <= 1'b0;
                gap_q       <= poll_gap_i;
            end else begin
                seen_cs_q <= seen_cs_q | spi_cs_o;
                if (rx_req_o && rx_valid_i) poll_busy_q <= !rx_data_i[7];
            end
            if (!spi_cs_o)                 first_byte_q <= 1'b1;
            else if (tx_valid_o && tx_ready_i) first_byte_q <= 1'b0;
            if (spi_cs_o)                  low_cnt_q <= '0;
            else if (low_cnt_q != '1)      low_cnt_q <= low_cnt_q + 1'b1;
        end
    end

    assert_tx_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o));

    assert_rx_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_req_o && !rx_valid_i |=> rx_req_o);

    assert_rx_framed_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_req_o |-> spi_cs_o);

    assert_idle_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> !spi_cs_o && !tx_valid_o && !rx_req_o && !done_o && !err_o);

    assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o && !busy_o);

    assert_err_pulse_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |=> !err_o && !busy_o);

    assert_err_silent_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |-> !seen_cs_q && !done_o);

    assert_opcode_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        spi_cs_o && tx_valid_o && first_byte_q |->
            (tx_data_o == 8'h50 || tx_data_o == 8'h81 || tx_data_o == 8'hD7));

    assert_poll_gap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(spi_cs_o) && poll_busy_q |-> low_cnt_q > {1'b0, gap_q});
endmodule

bind flash_erase_seq ferase_checker #(.GAP_W(GAP_W)) chk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .poll_gap_i (poll_gap_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .err_o      (err_o),
    .spi_cs_o   (spi_cs_o),
    .tx_valid_o (tx_valid_o),
    .tx_data_o  (tx_data_o),
    .tx_ready_i (tx_ready_i),
    .rx_req_o   (rx_req_o),
    .rx_valid_i (rx_valid_i),
    .rx_data_i  (rx_data_i)
);

// File: tb/flash_erase_seq_tb_top.sv
module flash_erase_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [23:0] start_addr_i = '0;
    logic [23:0] len_i = '0;
    logic [11:0] page_size_i = '0;
    logic [3:0]  page_shift_i = '0;
    logic [7:0]  poll_gap_i = '0;
    logic        busy_o, done_o, err_o, spi_cs_o, tx_valid_o, rx_req_o;
    logic [7:0]  tx_data_o;
    logic        tx_ready_i;
    logic        rx_valid_i;
    logic [7:0]  rx_data_i;

    always #10 clk = ~clk;

    flash_erase_seq dut_i (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start_i),
        .start_addr_i(start_addr_i), .len_i(len_i), .page_size_i(page_size_i),
        .page_shift_i(page_shift_i), .poll_gap_i(poll_gap_i),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .spi_cs_o(spi_cs_o),
        .tx_valid_o(tx_valid_o), .tx_data_o(tx_data_o), .tx_ready_i(tx_ready_i),
        .rx_req_o(rx_req_o), .rx_valid_i(rx_valid_i), .rx_data_i(rx_data_i)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // reference model of the page walk
    bit   model_active = 0;
    bit   expect_poll  = 0;
    bit   step_block   = 0;
    bit   gap_pending  = 0;
    bit   status_ready = 0;
    int   exp_page = 0, exp_left = 0, exp_shift = 0, gap_cfg = 0;
    int   busy_polls = 0;
    int   frames = 0;
    int   low_from = 0;
    logic [7:0] fbytes [16];
    int   flen = 0;
    bit   fread = 0;
    bit   cs_prev = 0;
    bit   tx_wait = 0;
    logic [7:0] tx_wait_data = '0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic bit f_block(input int page, input int left);
        return (page % 8 == 0) && (left >= 8);
    endfunction

    function automatic int f_dev(input int page, input int shift);
        return (page << shift) & 32'h00FF_FFFF;
    endfunction

    task automatic end_frame();
        int dev;
        frames++;
        if (!model_active) begin
            check(0, "R1/R9 traffic without work", flen, 0);
        end else if (!expect_poll) begin
            step_block = f_block(exp_page, exp_left);
            dev = f_dev(exp_page, exp_shift);
            check(flen == 4, "R3 erase frame length", flen, 4);
            check(fbytes[0] == (step_block ? 8'h50 : 8'h81), "R2 opcode",
                  int'(fbytes[0]), step_block ? 32'h50 : 32'h81);
            check(fbytes[1] == dev[23:16], "R3 address high", int'(fbytes[1]), int'(dev[23:16]));
            check(fbytes[2] == dev[15:8], "R3 address mid", int'(fbytes[2]), int'(dev[15:8]));
            check(fbytes[3] == 8'h00, "R3 trailing zero", int'(fbytes[3]), 0);
            expect_poll = 1;
            busy_polls  = int'($urandom_range(0, 3));
        end else begin
            check(flen == 1 && fbytes[0] == 8'hD7, "R4 poll opcode", int'(fbytes[0]), 32'hD7);
            check(fread, "R4 poll read", int'(fread), 1);
            if (status_ready) begin
                exp_page   += step_block ? 8 : 1;   // R5 advance
                exp_left   -= step_block ? 8 : 1;
                expect_poll = 0;
                gap_pending = 0;
            end else begin
                gap_pending = 1;
            end
        end
    endtask

    // byte-level port model
    initial begin
        tx_ready_i = 1'b0;
        rx_valid_i = 1'b0;
        rx_data_i  = 8'h00;
        forever begin
            @(negedge clk);
            cyc++;
            if (tx_wait)
                check(tx_valid_o && tx_data_o == tx_wait_data, "R10 send hold",
                      int'(tx_data_o), int'(tx_wait_data));
            if (rx_req_o && !spi_cs_o) check(0, "R10 receive outside frame", 1, 0);
            if (spi_cs_o && !cs_prev) begin
                flen  = 0;
                fread = 0;
                if (gap_pending)
                    check((cyc - low_from) >= gap_cfg + 1, "R6 poll spacing",
                          cyc - low_from, gap_cfg + 1);
            end
            if (!spi_cs_o && cs_prev) begin
                low_from = cyc;
                end_frame();
            end
            cs_prev    = spi_cs_o;
            tx_ready_i = 1'b0;
            rx_valid_i = 1'b0;
            tx_wait    = 0;
            if (tx_valid_o) begin
                if ($urandom_range(0, 2) != 0) begin
                    tx_ready_i = 1'b1;
                    if (flen < 16) fbytes[flen] = tx_data_o;
                    flen++;
                end else begin
                    tx_wait      = 1;
                    tx_wait_data = tx_data_o;
                end
            end
            if (rx_req_o && $urandom_range(0, 1) == 1) begin
                if (busy_polls > 0) begin
                    busy_polls--;
                    rx_data_i    = 8'(($urandom & 32'h7F));
                    status_ready = 0;
                end else begin
                    rx_data_i    = 8'(($urandom & 32'h7F) | 32'h80);
                    status_ready = 1;
                end
                rx_valid_i = 1'b1;
                fread      = 1;
            end
        end
    end

    task automatic run_req(input int addr, input int len, input int psz, input int shift,
                           input int gap, input bit exp_err, input bit intrude);
        bit finished;
        finished    = 0;
        frames      = 0;
        expect_poll = 0;
        gap_pending = 0;
        exp_shift   = shift;
        gap_cfg     = gap;
        if (!exp_err) begin
            exp_page = addr / psz;
            exp_left = len / psz;
        end
        model_active = !exp_err && len > 0;
        @(negedge clk);
        start_addr_i = 24'(addr);
        len_i        = 24'(len);
        page_size_i  = 12'(psz);
        page_shift_i = 4'(shift);
        poll_gap_i   = 8'(gap);
        start_i      = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o, "R7 busy after accept", int'(busy_o), 1);
        for (int k = 0; k < 20000; k++) begin
            if (done_o || err_o) begin
                finished = 1;
                break;
            end
            if (intrude && k == 70) begin   // R8 late request
                start_i      = 1'b1;
                start_addr_i = 24'(addr + 5 * psz);
                len_i        = 24'(psz);
                page_size_i  = 12'(psz / 2);
            end
            if (intrude && k == 71) start_i = 1'b0;
            @(negedge clk);
        end
        check(finished, "R7 request finished", int'(finished), 1);
        if (exp_err) begin
            check(err_o && !done_o, "R1 rejected", int'(err_o), 1);
            check(frames == 0, "R1 no traffic", frames, 0);
        end else begin
            check(done_o && !err_o, "R7 done pulse", int'(done_o), 1);
            check(exp_left == 0, "R5 range consumed", exp_left, 0);
            if (len == 0) check(frames == 0, "R9 empty request silent", frames, 0);
            if (intrude) check(exp_left == 0 && done_o, "R8 late start ignored", exp_left, 0);
        end
        @(negedge clk);
        check(!busy_o && !done_o && !err_o, "R7 back to idle",
              int'({busy_o, done_o, err_o}), 0);
        model_active = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int psz_tab [4] = '{256, 264, 512, 528};
        int shf_tab [4] = '{8, 9, 9, 10};
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o && !done_o && !err_o && !spi_cs_o && !tx_valid_o && !rx_req_o,
              "R7 reset state", int'(busy_o), 0);

        run_req(8 * 264, 16 * 264, 264, 9, 2, 0, 0);   // R2 two blocks
        run_req(7 * 256, 9 * 256, 256, 8, 1, 0, 0);    // R2 page then block
        run_req(8 * 512, 7 * 512, 512, 9, 0, 0, 0);    // R2 short of a block
        run_req(3 * 528, 0, 528, 10, 0, 0, 0);         // R9 empty
        run_req(4 * 264 + 4, 264, 264, 9, 0, 1, 0);    // R1 bad start
        run_req(2 * 256, 256 + 3, 256, 8, 0, 1, 0);    // R1 bad length
        run_req(0, 0, 0, 8, 0, 1, 0);                  // R1 zero page size
        run_req(16 * 528, 12 * 528, 528, 10, 3, 0, 1); // R8 intrusion
        for (int i = 0; i < 12; i++) begin
            int sel, pg, np, g;
            sel = int'($urandom_range(0, 3));
            pg  = int'($urandom_range(0, 40));
            np  = int'($urandom_range(1, 20));
            g   = int'($urandom_range(0, 6));
            run_req(pg * psz_tab[sel], np * psz_tab[sel], psz_tab[sel], shf_tab[sel], g, 0, 0);
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule